// File: doc/BRIEF.md
# Signal Voltage Switch Sequencer

This block runs the host side of moving an SD bus from 3.3 V to 1.8 V signalling. While idle, a prepare pulse turns on forced clock toggling, ahead of the voltage-switch command. After the card has answered that command, a start pulse with a 1.8 V target begins the switch.

The sequencer waits, then checks that the card holds CMD and DAT[3:0] low. It forces the card clock to stop and then asks the regulator for 1.8 V. After the regulator has had time to settle, it restarts clock toggling. After one more wait it checks that all five lines read high. A failed check ends the run with an error. With a 3.3 V target, the block changes only the regulator select and clears the clock controls. Every run ends with a single-cycle done pulse, and the error flag is valid in that same cycle.

Line levels pass through a synchroniser before they are judged. All three waits are cycle-count parameters.

Top module: `sigv_switch_seq`

## Requirements
- R1: While idle, a `prep_i` pulse sets `clk_toggle_o` to 1 on the next clock edge.
- R2: A start with `target_low_i`=0 (3.3 V) gives, on the next edge, `vsel_low_o`=0, `clk_toggle_o`=0, `clk_stop_o`=0, `card_clk_en_o`=1, and `done_o`=1 with `err_o`=0. No line check takes place.
- R3: With `target_low_i`=1 (1.8 V), the five lines are judged WAIT_RSP_CYC+1 edges after start. If any of them is high, the run ends at that edge with `done_o`=1 and `err_o`=1. The clock controls and the regulator select are left as they were.
- R4: When the low check passes, `clk_stop_o` rises and `clk_toggle_o` falls at that edge. `vsel_low_o` rises one edge later, never before the stop.
- R5: WAIT_REG_CYC edges after `vsel_low_o` rises, `clk_toggle_o` returns to 1 and `clk_stop_o` to 0.
- R6: WAIT_HI_CYC+1 edges after R5, the lines are judged again. If not all five read high, `clk_toggle_o`, `clk_stop_o` and `card_clk_en_o` all go to 0, and the run ends with `done_o`=1 and `err_o`=1.
- R7: If the high check passes, the run ends with `done_o`=1, `err_o`=0, and both `clk_toggle_o` and `clk_stop_o` at 0. `vsel_low_o` stays at 1.
- R8: A start pulse that arrives during a running sequence is ignored.
- R9: `done_o` is a single-cycle pulse. `err_o` is 1 only in a cycle where `done_o` is 1. Every start re-asserts `card_clk_en_o`.
- R10: After reset, `card_clk_en_o`=1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| prep_i | input | 1 | Enables forced clock toggling while idle |
| start_i | input | 1 | Starts a switch sequence |
| target_low_i | input | 1 | 1 selects 1.8 V, 0 selects 3.3 V |
| cmd_line_i | input | 1 | CMD line level |
| dat_lines_i | input | DAT_W | DAT line levels |
| clk_toggle_o | output | 1 | Forced card clock toggling |
| clk_stop_o | output | 1 | Forced card clock stop |
| card_clk_en_o | output | 1 | Card clock enable |
| vsel_low_o | output | 1 | Regulator select, 1 = 1.8 V |
| done_o | output | 1 | End-of-sequence pulse |
| err_o | output | 1 | Abort flag, valid with done_o |

## Verification
A wrong state or a wrong wait count shows up on the clock-control pins within one cycle of the point the requirements fix. It appears as a stop, restart or regulator edge at the wrong edge index, or as a done pulse that is early or late. A fault in judging the lines shows up at the end of the run: the error flag takes the wrong value, or the clock enable is dropped when it should not be. Sweeping all 32 line patterns at each of the two checks covers every line that could decide the outcome.

// File: rtl/sigv_pkg.sv
package sigv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RSP,
        ST_CHK_LO,
        ST_REG_SW,
        ST_WAIT_REG,
        ST_WAIT_HI,
        ST_CHK_HI
    } sigv_state_t;

    typedef struct packed {
        logic toggle;
        logic stop;
        logic en;
    } sigv_clkctl_t;

    localparam sigv_clkctl_t CLKCTL_RESET = '{toggle: 1'b0, stop: 1'b0, en: 1'b1};

    function automatic int unsigned sigv_max3(input int unsigned a, input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sigv_wait_timer.sv
module sigv_wait_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sigv_line_judge.sv
module sigv_line_judge #(
    parameter int DAT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_i,
    input  logic [DAT_W-1:0] dat_i,
    output logic             all_low_o,
    output logic             all_high_o
);
    localparam int LINES = DAT_W + 1;

    logic [LINES-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= {cmd_i, dat_i};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign all_low_o  = ~|stage_q[SYNC_STAGES-1];
    assign all_high_o = &stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/sigv_ctrl.sv
module sigv_ctrl
    import sigv_pkg::*;
#(
    parameter int unsigned WAIT_RSP_CYC = 100_000,
    parameter int unsigned WAIT_REG_CYC = 500_000,
    parameter int unsigned WAIT_HI_CYC  = 100_000,
    parameter int          CNT_W        = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prep_i,
    input  logic             start_i,
    input  logic             target_low_i,
    input  logic             all_low_i,
    input  logic             all_high_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output sigv_clkctl_t     clkctl_o,
    output logic             vsel_low_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] LD_RSP = CNT_W'(WAIT_RSP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REG = CNT_W'(WAIT_REG_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HI  = CNT_W'(WAIT_HI_CYC - 1);

    sigv_state_t  state_q;
    sigv_clkctl_t ctl_q;
    logic         vsel_q;
    logic         done_q;
    logic         err_q;

    always_comb begin
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && target_low_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LD_RSP;
                end
            end
            ST_REG_SW: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = LD_REG;
            end
            ST_WAIT_REG: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LD_HI;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CLKCTL_RESET;
            vsel_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl_q.en <= 1'b1;
                        if (target_low_i) begin
                            state_q <= ST_WAIT_RSP;
                        end else begin
                            vsel_q       <= 1'b0;
                            ctl_q.toggle <= 1'b0;
                            ctl_q.stop   <= 1'b0;
                            done_q       <= 1'b1;
                        end
                    end else if (prep_i) begin
                        ctl_q.toggle <= 1'b1;
                    end
                end
                ST_WAIT_RSP: begin
                    if (tmr_zero_i) state_q <= ST_CHK_LO;
                end
                ST_CHK_LO: begin
                    if (all_low_i) begin
                        ctl_q.stop   <= 1'b1;
                        ctl_q.toggle <= 1'b0;
                        state_q      <= ST_REG_SW;
                    end else begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_REG_SW: begin
                    vsel_q  <= 1'b1;
                    state_q <= ST_WAIT_REG;
                end
                ST_WAIT_REG: begin
                    if (tmr_zero_i) begin
                        ctl_q.toggle <= 1'b1;
                        ctl_q.stop   <= 1'b0;
                        state_q      <= ST_WAIT_HI;
                    end
                end
                ST_WAIT_HI: begin
                    if (tmr_zero_i) state_q <= ST_CHK_HI;
                end
                ST_CHK_HI: begin
                    ctl_q.toggle <= 1'b0;
                    ctl_q.stop   <= 1'b0;
                    done_q       <= 1'b1;
                    state_q      <= ST_IDLE;
                    if (!all_high_i) begin
                        err_q    <= 1'b1;
                        ctl_q.en <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign clkctl_o   = ctl_q;
    assign vsel_low_o = vsel_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
endmodule

// File: rtl/sigv_switch_seq.sv
module sigv_switch_seq
    import sigv_pkg::*;
#(
    parameter int unsigned WAIT_RSP_CYC = 100_000,
    parameter int unsigned WAIT_REG_CYC = 500_000,
    parameter int unsigned WAIT_HI_CYC  = 100_000,
    parameter int          DAT_W        = 4,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prep_i,
    input  logic             start_i,
    input  logic             target_low_i,
    input  logic             cmd_line_i,
    input  logic [DAT_W-1:0] dat_lines_i,
    output logic             clk_toggle_o,
    output logic             clk_stop_o,
    output logic             card_clk_en_o,
    output logic             vsel_low_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int unsigned MAX_WAIT = sigv_max3(WAIT_RSP_CYC, WAIT_REG_CYC, WAIT_HI_CYC);
    localparam int          CNT_W    = $clog2(MAX_WAIT) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             all_low;
    logic             all_high;
    sigv_clkctl_t     clkctl;

    sigv_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sigv_line_judge #(.DAT_W(DAT_W), .SYNC_STAGES(SYNC_STAGES)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd_line_i),
        .dat_i      (dat_lines_i),
        .all_low_o  (all_low),
        .all_high_o (all_high)
    );

    sigv_ctrl #(
        .WAIT_RSP_CYC (WAIT_RSP_CYC),
        .WAIT_REG_CYC (WAIT_REG_CYC),
        .WAIT_HI_CYC  (WAIT_HI_CYC),
        .CNT_W        (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .prep_i       (prep_i),
        .start_i      (start_i),
        .target_low_i (target_low_i),
        .all_low_i    (all_low),
        .all_high_i   (all_high),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .clkctl_o     (clkctl),
        .vsel_low_o   (vsel_low_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    assign clk_toggle_o  = clkctl.toggle;
    assign clk_stop_o    = clkctl.stop;
    assign card_clk_en_o = clkctl.en;
endmodule

// File: rtl/sigv_switch_seq_chk.sv
module sigv_switch_seq_chk (
    input logic clk,
    input logic rst,
    input logic clk_toggle_o,
    input logic clk_stop_o,
    input logic card_clk_en_o,
    input logic vsel_low_o,
    input logic done_o,
    input logic err_o
);
    // R4: the regulator is switched only while the clock is held stopped
    a_r4_stop_before_vsel: assert property (@(posedge clk) disable iff (rst)
        $rose(vsel_low_o) |-> clk_stop_o);

    // R4: forced stop and forced toggle are never requested together
    a_r4_stop_toggle_excl: assert property (@(posedge clk) disable iff (rst)
        !(clk_toggle_o && clk_stop_o));

    // R5: leaving the stop mid-run means toggling at 1.8 V
    a_r5_restart_at_low_v: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_stop_o) && !done_o) |-> (clk_toggle_o && vsel_low_o));

    // R6: the card clock enable drops only at an erroring end
    a_r6_clken_drop_on_err: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk_en_o) |-> (done_o && err_o));

    // R7: a clean end leaves the clock idle
    a_r7_clean_end_idle: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (!clk_toggle_o && !clk_stop_o));

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: error only alongside done
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
endmodule

bind sigv_switch_seq sigv_switch_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .clk_toggle_o  (clk_toggle_o),
    .clk_stop_o    (clk_stop_o),
    .card_clk_en_o (card_clk_en_o),
    .vsel_low_o    (vsel_low_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/sigv_switch_seq_bench.sv
module sigv_switch_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T1 = 4;
    localparam int T2 = 6;
    localparam int T3 = 3;
    localparam int KMAX = T1 + T2 + T3 + 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prep = 1'b0;
    logic       start = 1'b0;
    logic       tlow = 1'b0;
    logic       cmd_l = 1'b1;
    logic [3:0] dat_l = 4'hF;
    logic       tog, stp, cen, vsel, done, err;

    int checks = 0;
    int errors = 0;
    bit prior_tog = 1'b0;
    bit prior_vsel = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigv_switch_seq #(
        .WAIT_RSP_CYC (T1),
        .WAIT_REG_CYC (T2),
        .WAIT_HI_CYC  (T3),
        .DAT_W        (4),
        .SYNC_STAGES  (2)
    ) u_sigv_switch_seq (
        .clk           (clk),
        .rst           (rst),
        .prep_i        (prep),
        .start_i       (start),
        .target_low_i  (tlow),
        .cmd_line_i    (cmd_l),
        .dat_lines_i   (dat_l),
        .clk_toggle_o  (tog),
        .clk_stop_o    (stp),
        .card_clk_en_o (cen),
        .vsel_low_o    (vsel),
        .done_o        (done),
        .err_o         (err)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp_v,
                         input int k);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s k=%0d {done,err,tog,stop,vsel,clken} actual=%b expected=%b",
                     tag, k, act, exp_v);
        end
    endtask

    task automatic set_lines(input int pat);
        cmd_l = pat[4];
        dat_l = pat[3:0];
    endtask

    // Expected outputs k edges after the start edge (k=0 is the start edge).
    function automatic logic [5:0] expect_at(input bit tl, input int lp, input int hp,
                                             input int k, input bit ptog, input bit pvsel);
        int  kd;
        bit  d, e, t, s, v, c;
        if (!tl) begin
            d = (k == 0); e = 0; t = 0; s = 0; v = 0; c = 1;
        end else if (lp != 0) begin
            kd = T1 + 1;
            d = (k == kd); e = d; t = ptog; s = 0; v = pvsel; c = 1;
        end else begin
            kd = T1 + T2 + T3 + 3;
            d = (k == kd); e = d && (hp != 31);
            c = !(k >= kd && hp != 31);
            if (k <= T1) begin
                t = ptog; s = 0; v = pvsel;
            end else if (k < T1 + 2 + T2) begin
                t = 0; s = 1; v = (k >= T1 + 2) ? 1'b1 : pvsel;
            end else if (k < kd) begin
                t = 1; s = 0; v = 1;
            end else begin
                t = 0; s = 0; v = 1;
            end
        end
        return {d, e, t, s, v, c};
    endfunction

    function automatic string tag_at(input bit tl, input int lp, input int hp, input int k);
        int kd;
        kd = T1 + T2 + T3 + 3;
        if (!tl) return "R2";
        if (lp != 0 || k <= T1) return "R3";
        if (k < T1 + 2 + T2) return "R4";
        if (k < kd) return "R5";
        if (k == kd) return (hp != 31) ? "R6" : "R7";
        return "R9";
    endfunction

    task automatic run_seq(input bit tl, input int lp, input int hp, input bit inject);
        logic [5:0] ev;
        if (tl) begin
            set_lines(lp);
            @(negedge clk) prep = 1'b1;
            @(negedge clk) prep = 1'b0;
            check("R1", {1'b0, 1'b0, tog, 1'b0, 1'b0, 1'b0}, 6'b001000, -1);
            prior_tog = 1'b1;
            repeat (4) @(negedge clk);
        end
        start = 1'b1;
        tlow  = tl;
        for (int k = 0; k <= KMAX; k++) begin
            @(negedge clk);
            start = 1'b0;
            ev = expect_at(tl, lp, hp, k, prior_tog, prior_vsel);
            check(inject ? "R8" : tag_at(tl, lp, hp, k),
                  {done, err, tog, stp, vsel, cen}, ev, k);
            if (k == T1 + 2) set_lines(hp);
            if (inject && k == 3) begin
                start = 1'b1;
                tlow  = 1'b0;
            end
        end
        ev = expect_at(tl, lp, hp, KMAX, prior_tog, prior_vsel);
        prior_tog  = ev[3];
        prior_vsel = ev[1];
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10", {done, err, tog, stp, vsel, cen}, 6'b000001, -1);

        // R2: plain 3.3 V selection
        run_seq(1'b0, 0, 31, 1'b0);

        // R3/R4/R5/R7: every low-check pattern, high check clean
        for (int lp = 0; lp < 32; lp++) run_seq(1'b1, lp, 31, 1'b0);

        // R6/R7: every high-check pattern after a clean low check
        for (int hp = 0; hp < 32; hp++) run_seq(1'b1, 0, hp, 1'b0);

        // R9: a new start re-enables the card clock after an error run
        run_seq(1'b1, 0, 5, 1'b0);
        run_seq(1'b0, 0, 31, 1'b0);

        // R8: start during a running switch is ignored
        run_seq(1'b1, 0, 31, 1'b1);

        // back to 3.3 V after a successful switch
        run_seq(1'b0, 0, 31, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule